// File: doc/BRIEF.md
# Shift and Rotate Unit with Flags

This block is a purely combinational shifter for a processor execution pipeline. It takes an operation code, an operand size of 8, 16 or 32 bits, a destination operand, a second operand and a shift count. It returns the shifted or rotated value and a set of arithmetic flags. The incoming carry, overflow, sign, zero and parity flags are also inputs. Rotate-through-carry uses the carry as an extra ring bit. An operation that has no effect hands all five flags through unchanged.

Internally the operation runs as a chain of identical single-bit step cells. The masked count picks the tap on the chain. The tap gives the result and the last bit shifted out, and it also gives the value one step earlier, which is needed for the overflow rule. Decode, register files and memory operands belong to the surrounding pipeline.

Top module: `shift_rotate_unit`

## Requirements
- R1: Op code 0 (shift left) moves bits up and fills the low bit with 0. Carry out is the last bit pushed out of the top of the operand. For a count equal to the width this is bit 0 of the destination, and the result is 0.
- R2: Op code 1 (logical right) fills the top bit of the operand with 0. Carry out is the last bit pushed out of bit 0.
- R3: Op code 2 (arithmetic right) refills the top bit with the old sign bit, so the result rounds toward negative infinity. Overflow out is 0 and the sign is kept.
- R4: Op codes 3 (rotate left) and 4 (rotate right) rotate within the operand width. Carry out equals the bit that last wrapped around: bit 0 of the result for left, the top bit of the result for right.
- R5: Op codes 5 (left through carry) and 6 (right through carry) rotate a ring of width+1 bits made of the operand plus the carry.
- R6: Op code 7 (double left) fills vacated low bits from the top bits of the second operand. Op code 8 (double right) fills vacated high bits from the low bits of the second operand. Carry is the last bit pushed out of the destination.
- R7: For a nonzero count, overflow out is 1 exactly when the top bit of the operand differs before and after the final single-bit step.
- R8: For op codes 0, 1, 2, 7 and 8 with a nonzero count, sign out is the top bit of the result and zero out is 1 when the result is 0. Parity out is 1 when bits 7:0 of the result hold an even number of ones.
- R9: The rotate op codes 3 to 6 pass the sign, zero and parity inputs to their outputs unchanged.
- R10: Only the low 5 bits of the count are used. A masked count of 0 gives result = destination, and all five flag outputs equal their inputs.
- R11: Size code 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Operand bits above the width are ignored, and result bits above the width are 0.
- R12: Op codes 9 to 15 act as no operation: result = destination, and all flags pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Fill source for double shifts |
| cnt_i | input | 8 | Shift count (low 5 bits used) |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| sf_i | input | 1 | Incoming sign flag |
| zf_i | input | 1 | Incoming zero flag |
| pf_i | input | 1 | Incoming parity flag |
| res_o | output | 32 | Result, zero above the operand width |
| cf_o | output | 1 | Carry out |
| of_o | output | 1 | Overflow out |
| sf_o | output | 1 | Sign out |
| zf_o | output | 1 | Zero out |
| pf_o | output | 1 | Parity out |

## Verification
The block holds no stored state. A bad intermediate value in the step chain therefore shows at the ports in the same evaluation in which the inputs change.

- A wrong step cell corrupts every tap at or after its position. Result and carry errors appear only for counts at least that large.
- A slip in choosing the earlier tap shows up as a wrong overflow while result and carry stay correct. This is why the overflow is checked on multi-bit counts whose second-to-last step has a different top bit.
- Masking faults show as nonzero upper result bits, or as a wrong fill, in the 8- and 16-bit cases.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [3:0] {
        OP_SHL  = 4'd0,
        OP_SHR  = 4'd1,
        OP_SAR  = 4'd2,
        OP_ROL  = 4'd3,
        OP_ROR  = 4'd4,
        OP_RCL  = 4'd5,
        OP_RCR  = 4'd6,
        OP_DSHL = 4'd7,
        OP_DSHR = 4'd8
    } sru_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } sru_size_e;

endpackage

// File: rtl/sru_step.sv
// One single-bit step of any supported operation, on a masked operand.
module sru_step
    import sru_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  sru_op_e          op_i,
    input  logic [XLEN-1:0]  msk_i,
    input  logic [XLEN-1:0]  top_i,
    input  logic [XLEN-1:0]  v_i,
    input  logic             c_i,
    input  logic [XLEN-1:0]  s_i,
    output logic [XLEN-1:0]  v_o,
    output logic             c_o,
    output logic [XLEN-1:0]  s_o
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};

    logic v_msb;
    logic s_msb;
    logic v_lsb;

    always_comb begin
        v_msb = |(v_i & top_i);
        s_msb = |(s_i & top_i);
        v_lsb = v_i[0];
        v_o   = v_i;
        c_o   = c_i;
        s_o   = s_i;
        case (op_i)
            OP_SHL: begin
                v_o = (v_i << 1) & msk_i;
                c_o = v_msb;
            end
            OP_SHR: begin
                v_o = v_i >> 1;
                c_o = v_lsb;
            end
            OP_SAR: begin
                v_o = (v_i >> 1) | (v_msb ? top_i : '0);
                c_o = v_lsb;
            end
            OP_ROL: begin
                v_o = ((v_i << 1) & msk_i) | (v_msb ? ONE : '0);
                c_o = v_msb;
            end
            OP_ROR: begin
                v_o = (v_i >> 1) | (v_lsb ? top_i : '0);
                c_o = v_lsb;
            end
            OP_RCL: begin
                v_o = ((v_i << 1) & msk_i) | (c_i ? ONE : '0);
                c_o = v_msb;
            end
            OP_RCR: begin
                v_o = (v_i >> 1) | (c_i ? top_i : '0);
                c_o = v_lsb;
            end
            OP_DSHL: begin
                v_o = ((v_i << 1) & msk_i) | (s_msb ? ONE : '0);
                c_o = v_msb;
                s_o = (s_i << 1) & msk_i;
            end
            OP_DSHR: begin
                v_o = (v_i >> 1) | (s_i[0] ? top_i : '0);
                c_o = v_lsb;
                s_o = s_i >> 1;
            end
            default: begin
                v_o = v_i;
                c_o = c_i;
                s_o = s_i;
            end
        endcase
    end

endmodule

// File: rtl/sru_flags.sv
// Result-derived flags: sign from the width's top bit, zero, low-byte parity.
module sru_flags #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] res_i,
    input  logic [XLEN-1:0] top_i,
    output logic            sf_o,
    output logic            zf_o,
    output logic            pf_o
);
    always_comb begin
        sf_o = |(res_i & top_i);
        zf_o = (res_i == '0);
        pf_o = ~^res_i[7:0];
    end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CNT_BITS = 5,
    parameter int CNT_IN_W = 8
) (
    input  logic [3:0]          op_i,
    input  logic [1:0]          size_i,
    input  logic [XLEN-1:0]     dst_i,
    input  logic [XLEN-1:0]     src_i,
    input  logic [CNT_IN_W-1:0] cnt_i,
    input  logic                cf_i,
    input  logic                of_i,
    input  logic                sf_i,
    input  logic                zf_i,
    input  logic                pf_i,
    output logic [XLEN-1:0]     res_o,
    output logic                cf_o,
    output logic                of_o,
    output logic                sf_o,
    output logic                zf_o,
    output logic                pf_o
);
    localparam int STAGES = 1 << CNT_BITS;

    sru_op_e              op_e;
    logic [XLEN-1:0]      msk;
    logic [XLEN-1:0]      top_bit;
    logic [CNT_BITS-1:0]  cnt;
    logic [CNT_BITS-1:0]  pidx;
    logic                 unused_cnt;
    logic                 op_known;
    logic                 op_shift;

    logic [XLEN-1:0] stg_v [STAGES];
    logic            stg_c [STAGES];
    logic [XLEN-1:0] stg_s [STAGES];

    logic [XLEN-1:0] sel_v;
    logic [XLEN-1:0] prev_v;
    logic            new_sf;
    logic            new_zf;
    logic            new_pf;

    assign op_e       = sru_op_e'(op_i);
    assign cnt        = cnt_i[CNT_BITS-1:0];
    assign unused_cnt = ^cnt_i[CNT_IN_W-1:CNT_BITS];
    assign pidx       = cnt - {{(CNT_BITS-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (size_i)
            SZ_BYTE: msk = {{(XLEN-8){1'b0}}, 8'hFF};
            SZ_HALF: msk = {{(XLEN-16){1'b0}}, 16'hFFFF};
            default: msk = '1;
        endcase
        top_bit = msk ^ (msk >> 1);
    end

    always_comb begin
        op_known = (op_i <= 4'd8);
        op_shift = (op_e == OP_SHL) || (op_e == OP_SHR) || (op_e == OP_SAR) ||
                   (op_e == OP_DSHL) || (op_e == OP_DSHR);
    end

    assign stg_v[0] = dst_i & msk;
    assign stg_c[0] = cf_i;
    assign stg_s[0] = src_i & msk;

    generate
        for (genvar k = 1; k < STAGES; k++) begin : g_step
            sru_step #(.XLEN(XLEN)) u_step (
                .op_i  (op_e),
                .msk_i (msk),
                .top_i (top_bit),
                .v_i   (stg_v[k-1]),
                .c_i   (stg_c[k-1]),
                .s_i   (stg_s[k-1]),
                .v_o   (stg_v[k]),
                .c_o   (stg_c[k]),
                .s_o   (stg_s[k])
            );
        end
    endgenerate

    assign sel_v  = stg_v[cnt];
    assign prev_v = stg_v[pidx];

    sru_flags #(.XLEN(XLEN)) u_flags (
        .res_i (sel_v),
        .top_i (top_bit),
        .sf_o  (new_sf),
        .zf_o  (new_zf),
        .pf_o  (new_pf)
    );

    always_comb begin
        res_o = dst_i & msk;
        cf_o  = cf_i;
        of_o  = of_i;
        sf_o  = sf_i;
        zf_o  = zf_i;
        pf_o  = pf_i;
        if (op_known && (cnt != '0)) begin
            res_o = sel_v;
            cf_o  = stg_c[cnt];
            of_o  = (|(sel_v & top_bit)) ^ (|(prev_v & top_bit));
            if (op_shift) begin
                sf_o = new_sf;
                zf_o = new_zf;
                pf_o = new_pf;
            end
        end
    end

    // Checks on the outputs against the inputs
    always_comb begin
        assert_sar_no_ovf_R3: assert (!(op_e == OP_SAR && cnt != '0) || !of_o);
        assert_sar_sign_R3: assert (!(op_e == OP_SAR && cnt != '0) ||
                                    ((|(res_o & top_bit)) == (|(dst_i & top_bit))));
        assert_rol_carry_R4: assert (!(op_e == OP_ROL && cnt != '0) || (cf_o == res_o[0]));
        assert_ror_carry_R4: assert (!(op_e == OP_ROR && cnt != '0) ||
                                     (cf_o == (|(res_o & top_bit))));
        assert_shl_one_R1: assert (!(op_e == OP_SHL && cnt == 1) ||
                                   (cf_o == (|(dst_i & top_bit))));
        assert_upper_clear_R11: assert ((res_o & ~msk) == '0);
    end

endmodule

// File: tb/sim_shift_rotate_unit.sv
`timescale 1ns/1ps
module sim_shift_rotate_unit;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  op   = '0;
    logic [1:0]  size = '0;
    logic [31:0] dst  = '0;
    logic [31:0] src  = '0;
    logic [7:0]  cnt  = '0;
    logic        cfi = 1'b0, ofi = 1'b0, sfi = 1'b0, zfi = 1'b0, pfi = 1'b0;
    logic [31:0] res;
    logic        cfo, ofo, sfo, zfo, pfo;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    shift_rotate_unit u0 (
        .op_i(op), .size_i(size), .dst_i(dst), .src_i(src), .cnt_i(cnt),
        .cf_i(cfi), .of_i(ofi), .sf_i(sfi), .zf_i(zfi), .pf_i(pfi),
        .res_o(res), .cf_o(cfo), .of_o(ofo), .sf_o(sfo), .zf_o(zfo), .pf_o(pfo)
    );

    // flag vectors are {carry, overflow, sign, zero, parity}
    task automatic apply(input logic [3:0] o, input logic [1:0] s, input logic [31:0] d,
                         input logic [31:0] sr, input logic [7:0] c, input logic [4:0] fin);
        @(negedge clk);
        op = o; size = s; dst = d; src = sr; cnt = c;
        {cfi, ofi, sfi, zfi, pfi} = fin;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [31:0] er, input logic [4:0] ef);
        n_chk++;
        if (res !== er) begin
            n_fail++;
            $display("FAIL %s result actual=%h expected=%h", tag, res, er);
        end
        n_chk++;
        if ({cfo, ofo, sfo, zfo, pfo} !== ef) begin
            n_fail++;
            $display("FAIL %s flags actual=%b expected=%b", tag, {cfo, ofo, sfo, zfo, pfo}, ef);
        end
    endtask

    task automatic t_idle_R10();
        apply(4'd0, 2'd0, 32'h0, 32'h0, 8'd0, 5'b00000);
        expect_out("R10 idle", 32'h0, 5'b00000);
    endtask

    task automatic t_shl_R1();
        apply(4'd0, 2'd0, 32'h82, 32'h0, 8'd1, 5'b00010);
        expect_out("R1 shl1", 32'h04, 5'b11000);
        apply(4'd0, 2'd0, 32'h64, 32'h0, 8'd2, 5'b00010);
        expect_out("R1 R7 shl2", 32'h90, 5'b10101);
        apply(4'd0, 2'd0, 32'hFF, 32'h0, 8'd8, 5'b00000);
        expect_out("R1 shl width", 32'h0, 5'b11011);
        apply(4'd0, 2'd2, 32'h8000_0001, 32'h0, 8'd31, 5'b00000);
        expect_out("R1 shl31 word", 32'h8000_0000, 5'b01101);
    endtask

    task automatic t_shr_R2();
        apply(4'd1, 2'd0, 32'hF1, 32'h0, 8'd1, 5'b00010);
        expect_out("R2 shr", 32'h78, 5'b11001);
    endtask

    task automatic t_sar_R3();
        apply(4'd2, 2'd0, 32'hF1, 32'h0, 8'd1, 5'b00010);
        expect_out("R3 sar", 32'hF8, 5'b10100);
        apply(4'd2, 2'd1, 32'h0000_8000, 32'h0, 8'd15, 5'b00010);
        expect_out("R3 R11 sar half", 32'h0000_FFFF, 5'b00101);
    endtask

    task automatic t_rot_R4();
        apply(4'd4, 2'd1, 32'h1234, 32'h0, 8'd4, 5'b00010);
        expect_out("R4 R9 ror", 32'h4123, 5'b01010);
        apply(4'd3, 2'd0, 32'h40, 32'h0, 8'd2, 5'b00010);
        expect_out("R4 R7 rol", 32'h01, 5'b11010);
    endtask

    task automatic t_rcx_R5();
        apply(4'd5, 2'd0, 32'h80, 32'h0, 8'd1, 5'b00101);
        expect_out("R5 R9 rcl", 32'h00, 5'b11101);
        apply(4'd6, 2'd0, 32'h01, 32'h0, 8'd1, 5'b10010);
        expect_out("R5 rcr", 32'h80, 5'b11010);
        apply(4'd5, 2'd0, 32'h5A, 32'h0, 8'd9, 5'b10010);
        expect_out("R5 rcl ring9", 32'h5A, 5'b11010);
    endtask

    task automatic t_dbl_R6();
        apply(4'd8, 2'd1, 32'h786A, 32'hAC36, 8'd4, 5'b00010);
        expect_out("R6 R8 dshr", 32'h6786, 5'b11000);
        apply(4'd7, 2'd1, 32'h923B, 32'hAC36, 8'd8, 5'b00010);
        expect_out("R6 R8 dshl", 32'h3BAC, 5'b00001);
    endtask

    task automatic t_mask_R10();
        apply(4'd0, 2'd0, 32'h82, 32'h0, 8'h20, 5'b10101);
        expect_out("R10 cnt32 hold", 32'h82, 5'b10101);
        apply(4'd0, 2'd0, 32'h82, 32'h0, 8'h21, 5'b00010);
        expect_out("R10 cnt33", 32'h04, 5'b11000);
    endtask

    task automatic t_size_R11();
        apply(4'd0, 2'd0, 32'hFFFF_FF82, 32'hFFFF_FFFF, 8'd1, 5'b00010);
        expect_out("R11 upper ignored", 32'h0000_0004, 5'b11000);
    endtask

    task automatic t_badop_R12();
        apply(4'hF, 2'd1, 32'h0001_1234, 32'h0, 8'd3, 5'b10101);
        expect_out("R12 undefined op", 32'h1234, 5'b10101);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_idle_R10();
        t_shl_R1();
        t_shr_R2();
        t_sar_R3();
        t_rot_R4();
        t_rcx_R5();
        t_dbl_R6();
        t_mask_R10();
        t_size_R11();
        t_badop_R12();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule